// File: doc/BRIEF.md
# Isochronous Receive Channel Filter

This block decides, one header at a time, whether an incoming isochronous packet should be taken in by the receiver. It reads the header quadlet for the transaction code, channel number, tag and sync field. It compares these fields with two independent receive ports. Each port has an enable, a 6-bit channel number and a 2-bit tag. An optional tag-qualification mode makes the tag count as well. A take-everything override accepts every isochronous packet.

The result is registered on the clock edge that samples the header strobe and then held until the next header arrives. The result gives an accept flag and says which port matched; port 1 wins when both match. The block also emits a single-clock pre-data pulse for an accepted packet whose sync field equals a programmed 4-bit pattern. This pulse is produced only when the data port is set up for isochronous reception.

Top module: `iso_chan_filter`

## Requirements
- R1: While reset is asserted and after its release with no header seen, `pkt_accept`, `hit_port1`, `hit_port2` and `predata_pulse` are all 0.
- R2: Header fields: tag = bits [15:14], channel = bits [13:8], tcode = bits [7:4], sync = bits [3:0]. Only tcode 4'hA is isochronous. Any other tcode yields accept 0, no port hit and no pulse, even with take-all set.
- R3: A port matches only when its enable is 1 and the header channel equals its channel field. A disabled port never matches. `pkt_accept` is 1 when any port matches.
- R4: With `tag_qual_en` = 1, a port also needs the header tag to equal its tag field. With it 0, the tag has no effect.
- R5: With `take_all` = 1, every isochronous header gives `pkt_accept` = 1 whatever its channel and tag. The hit outputs still report only genuine port matches.
- R6: When both ports match one header, only `hit_port1` is 1. The hit outputs are never both 1.
- R7: The outputs change on the clock edge that samples `hdr_valid` = 1. `pkt_accept` and the hit outputs then stay unchanged until the next header.
- R8: `predata_pulse` is 1 for exactly the one cycle following a header that is accepted and whose sync field equals `sync_pattern`, when `dm_rx_en` = 1 and `dm_async` = 0.
- R9: `predata_pulse` stays 0 when `dm_async` = 1 or `dm_rx_en` = 0, even for an accepted header with a matching sync field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hdr_valid | input | 1 | Header quadlet valid strobe |
| hdr_word | input | 32 | Received packet header quadlet |
| port1_en | input | 1 | Receive port 1 enable |
| port1_chan | input | 6 | Receive port 1 channel number |
| port1_tag | input | 2 | Receive port 1 tag value |
| port2_en | input | 1 | Receive port 2 enable |
| port2_chan | input | 6 | Receive port 2 channel number |
| port2_tag | input | 2 | Receive port 2 tag value |
| tag_qual_en | input | 1 | Require tag match as well as channel |
| take_all | input | 1 | Accept every isochronous packet |
| sync_pattern | input | 4 | Sync field value that triggers pre-data |
| dm_rx_en | input | 1 | Data port configured for receive |
| dm_async | input | 1 | Data port configured for asynchronous traffic |
| pkt_accept | output | 1 | Last header accepted |
| hit_port1 | output | 1 | Last header matched port 1 |
| hit_port2 | output | 1 | Last header matched port 2 and not port 1 |
| predata_pulse | output | 1 | One-cycle pre-data strobe |

## Verification
Each result is due exactly one register stage after its stimulus. The accept flag, the hit flags and the pre-data pulse all appear in the cycle after the edge that sampled `hdr_valid`. The pulse drops again one cycle later, while the other outputs hold. The bench runs a behavioural reference updated on the same edge and compares all four outputs one time unit after every rising edge. Idle cycles between headers are checked against the held values, and the pulse is checked for its return to 0.

// File: rtl/iso_chan_filter.sv
module iso_chan_filter #(
  parameter int CHAN_W    = 6,
  parameter int TAG_W     = 2,
  parameter int SY_W      = 4,
  parameter logic [3:0] ISO_TCODE = 4'hA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_valid,
  input  logic [31:0]       hdr_word,
  input  logic              port1_en,
  input  logic [CHAN_W-1:0] port1_chan,
  input  logic [TAG_W-1:0]  port1_tag,
  input  logic              port2_en,
  input  logic [CHAN_W-1:0] port2_chan,
  input  logic [TAG_W-1:0]  port2_tag,
  input  logic              tag_qual_en,
  input  logic              take_all,
  input  logic [SY_W-1:0]   sync_pattern,
  input  logic              dm_rx_en,
  input  logic              dm_async,
  output logic              pkt_accept,
  output logic              hit_port1,
  output logic              hit_port2,
  output logic              predata_pulse
);
  localparam int SY_LO   = 0;
  localparam int TC_LO   = SY_LO + SY_W;
  localparam int CH_LO   = TC_LO + 4;
  localparam int TAG_LO  = CH_LO + CHAN_W;

  logic [CHAN_W-1:0] h_chan;
  logic [TAG_W-1:0]  h_tag;
  logic [3:0]        h_tcode;
  logic [SY_W-1:0]   h_sy;
  logic              is_iso, m1, m2, acc_n;

  assign h_sy    = hdr_word[SY_LO +: SY_W];
  assign h_tcode = hdr_word[TC_LO +: 4];
  assign h_chan  = hdr_word[CH_LO +: CHAN_W];
  assign h_tag   = hdr_word[TAG_LO +: TAG_W];
  assign is_iso  = (h_tcode == ISO_TCODE);

  assign m1 = is_iso && port1_en && (h_chan == port1_chan) &&
              (!tag_qual_en || (h_tag == port1_tag));
  assign m2 = is_iso && port2_en && (h_chan == port2_chan) &&
              (!tag_qual_en || (h_tag == port2_tag));
  assign acc_n = m1 || m2 || (is_iso && take_all);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_accept    <= 1'b0;
      hit_port1     <= 1'b0;
      hit_port2     <= 1'b0;
      predata_pulse <= 1'b0;
    end else begin
      predata_pulse <= 1'b0;
      if (hdr_valid) begin
        pkt_accept    <= acc_n;
        hit_port1     <= m1;
        hit_port2     <= m2 && !m1;
        predata_pulse <= acc_n && (h_sy == sync_pattern) && dm_rx_en && !dm_async;
      end
    end
  end

  p_hit_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_port1, hit_port2}));

  p_hit_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_port1 || hit_port2) |-> pkt_accept);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(hdr_valid) |-> ($stable(pkt_accept) && $stable(hit_port1) && $stable(hit_port2)));

  p_pulse_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    predata_pulse |-> ($past(hdr_valid) && pkt_accept));

  p_no_async_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dm_async || !dm_rx_en) |-> !predata_pulse);

  p_take_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hdr_valid && take_all && (hdr_word[7:4] == ISO_TCODE)) |-> pkt_accept);

  p_non_iso_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hdr_valid && (hdr_word[7:4] != ISO_TCODE)) |-> !pkt_accept && !predata_pulse);
endmodule

// File: tb/iso_chan_filter_tb_top.sv
module iso_chan_filter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hdr_valid = 1'b0;
  logic [31:0] hdr_word = '0;
  logic p1_en = 0, p2_en = 0, tq = 0, tall = 0, rx = 0, asy = 0;
  logic [5:0] p1_ch = 0, p2_ch = 0;
  logic [1:0] p1_tg = 0, p2_tg = 0;
  logic [3:0] syp = 0;
  logic acc, h1, h2, pre;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  iso_chan_filter dut_i (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_word(hdr_word),
    .port1_en(p1_en), .port1_chan(p1_ch), .port1_tag(p1_tg),
    .port2_en(p2_en), .port2_chan(p2_ch), .port2_tag(p2_tg),
    .tag_qual_en(tq), .take_all(tall), .sync_pattern(syp),
    .dm_rx_en(rx), .dm_async(asy),
    .pkt_accept(acc), .hit_port1(h1), .hit_port2(h2), .predata_pulse(pre));

  logic e_acc = 0, e_h1 = 0, e_h2 = 0, e_pre = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_acc <= 0; e_h1 <= 0; e_h2 <= 0; e_pre <= 0;
    end else begin
      bit match [2];
      int en [2], ch [2], tg [2];
      int first;
      bit iso, any;
      en[0] = p1_en; ch[0] = p1_ch; tg[0] = p1_tg;
      en[1] = p2_en; ch[1] = p2_ch; tg[1] = p2_tg;
      iso = (hdr_word[7:4] == 4'hA);
      first = -1;
      any = 0;
      for (int k = 0; k < 2; k++) begin
        match[k] = iso && en[k] != 0 && ch[k] == int'(hdr_word[13:8]) &&
                   (tq == 0 || tg[k] == int'(hdr_word[15:14]));
        if (match[k] && first < 0) first = k;
        if (match[k]) any = 1;
      end
      e_pre <= 0;
      if (hdr_valid) begin
        e_acc <= any || (iso && tall);
        e_h1  <= (first == 0);
        e_h2  <= (first == 1);
        e_pre <= (any || (iso && tall)) && (hdr_word[3:0] == syp) && rx && !asy;
      end
    end
  end

  task automatic cmp(input string req);
    checks++;
    if ({acc, h1, h2, pre} !== {e_acc, e_h1, e_h2, e_pre}) begin
      fails++;
      $display("FAIL %s: acc/h1/h2/pre actual=%b%b%b%b expected=%b%b%b%b",
               req, acc, h1, h2, pre, e_acc, e_h1, e_h2, e_pre);
    end
  endtask

  task automatic cyc(input string req);
    @(posedge clk); #1;
    cmp(req);
  endtask

  function automatic logic [31:0] hdr(input logic [1:0] tg, input logic [5:0] ch,
                                      input logic [3:0] tc, input logic [3:0] sy);
    return {16'h0040, tg, ch, tc, sy};
  endfunction

  task automatic send(input logic [31:0] w, input string req);
    hdr_word = w; hdr_valid = 1;
    cyc(req);
    hdr_valid = 0;
    hdr_word = 32'hFFFF_FFFF;
    cyc("R7");
    cyc("R7");
  endtask

  initial begin
    #1;
    cmp("R1");
    repeat (3) cyc("R1");
    rst_n = 1;
    cyc("R1");
    if ({acc, h1, h2, pre} !== 4'b0) begin
      fails++; $display("FAIL R1: outputs actual=%b expected=0000", {acc, h1, h2, pre});
    end
    checks++;

    p1_en = 1; p1_ch = 6'd5; p1_tg = 2'd1;
    p2_en = 1; p2_ch = 6'd9; p2_tg = 2'd2;
    send(hdr(2'd0, 6'd5, 4'hA, 4'd0), "R3");
    if (!(acc && h1 && !h2)) begin fails++; $display("FAIL R3: port1 hit actual=%b%b%b expected=110", acc, h1, h2); end
    checks++;
    send(hdr(2'd3, 6'd9, 4'hA, 4'd0), "R3");
    send(hdr(2'd0, 6'd7, 4'hA, 4'd0), "R3");
    if (acc !== 1'b0) begin fails++; $display("FAIL R3: no-match accept actual=%b expected=0", acc); end
    checks++;
    p1_en = 0;
    send(hdr(2'd0, 6'd5, 4'hA, 4'd0), "R3");
    p1_en = 1;
    send(hdr(2'd1, 6'd5, 4'h1, 4'd0), "R2");
    tall = 1;
    send(hdr(2'd1, 6'd5, 4'h0, 4'd0), "R2");
    if (acc !== 1'b0) begin fails++; $display("FAIL R2: non-iso accept actual=%b expected=0", acc); end
    checks++;
    send(hdr(2'd3, 6'd33, 4'hA, 4'd0), "R5");
    if (!(acc && !h1 && !h2)) begin fails++; $display("FAIL R5: take-all actual=%b%b%b expected=100", acc, h1, h2); end
    checks++;
    send(hdr(2'd0, 6'd9, 4'hA, 4'd0), "R5");
    tall = 0;
    tq = 1;
    send(hdr(2'd0, 6'd5, 4'hA, 4'd0), "R4");
    if (acc !== 1'b0) begin fails++; $display("FAIL R4: tag mismatch accept actual=%b expected=0", acc); end
    checks++;
    send(hdr(2'd1, 6'd5, 4'hA, 4'd0), "R4");
    send(hdr(2'd2, 6'd9, 4'hA, 4'd0), "R4");
    tq = 0;
    p2_ch = 6'd5;
    send(hdr(2'd2, 6'd5, 4'hA, 4'd0), "R6");
    if (!(h1 && !h2)) begin fails++; $display("FAIL R6: priority actual=%b%b expected=10", h1, h2); end
    checks++;
    tq = 1;
    send(hdr(2'd2, 6'd5, 4'hA, 4'd0), "R6");
    tq = 0; p2_ch = 6'd9;

    rx = 1; asy = 0; syp = 4'd6;
    hdr_word = hdr(2'd0, 6'd5, 4'hA, 4'd6); hdr_valid = 1;
    cyc("R8");
    if (pre !== 1'b1) begin fails++; $display("FAIL R8: pulse actual=%b expected=1", pre); end
    checks++;
    hdr_valid = 0;
    cyc("R8");
    if (pre !== 1'b0) begin fails++; $display("FAIL R8: pulse width actual=%b expected=0", pre); end
    checks++;
    send(hdr(2'd0, 6'd5, 4'hA, 4'd7), "R8");
    send(hdr(2'd0, 6'd40, 4'hA, 4'd6), "R8");
    asy = 1;
    send(hdr(2'd0, 6'd5, 4'hA, 4'd6), "R9");
    if (pre !== 1'b0 && acc !== 1'b1) begin fails++; $display("FAIL R9: async pulse actual=%b expected=0", pre); end
    checks++;
    asy = 0; rx = 0;
    send(hdr(2'd0, 6'd5, 4'hA, 4'd6), "R9");
    rx = 1;
    hdr_word = hdr(2'd0, 6'd5, 4'hA, 4'd6); hdr_valid = 1;
    cyc("R8");
    hdr_word = hdr(2'd0, 6'd9, 4'hA, 4'd6);
    cyc("R8");
    hdr_valid = 0;
    cyc("R7");

    for (int i = 0; i < 200; i++) begin
      p1_en = ($urandom_range(0, 3) != 0); p2_en = ($urandom_range(0, 3) != 0);
      p1_ch = 6'($urandom_range(0, 3)); p2_ch = 6'($urandom_range(0, 3));
      p1_tg = 2'($urandom); p2_tg = 2'($urandom);
      tq = 1'($urandom); tall = ($urandom_range(0, 5) == 0);
      rx = 1'($urandom); asy = 1'($urandom); syp = 4'($urandom_range(0, 1));
      hdr_valid = 1'($urandom);
      hdr_word = hdr(2'($urandom), 6'($urandom_range(0, 3)),
                     ($urandom_range(0, 3) == 0) ? 4'h1 : 4'hA, 4'($urandom_range(0, 1)));
      cyc("R7");
    end
    hdr_valid = 0;
    cyc("R7");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R7: watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule